// File: doc/BRIEF.md
# UART host register and interrupt interface

This block is the register file that a UART presents to a parallel host bus. It sits between the host and separate receive and transmit engines, which are not part of this block. A host access is a single-cycle strobe qualified by a three-line chip select. A register-select line and a read/write line then pick one of four operations: load the transmit character, fetch the received character, load the configuration byte, or fetch the status byte. Read results appear on a plain output bus one cycle after the strobe, together with a valid flag.

The block holds the configuration byte and passes it to the engines. It latches each received character with its error flags. It keeps five interrupt causes, each with its own set event and its own clearing access, and drives an active-low interrupt line. It also drives an active-low request-to-send line. Two peripheral inputs are resynchronised before use: one is level-sensitive and one is edge-sensitive.

Top module: `uart_host_regs`

## Requirements
- R1: An access takes effect only in a cycle where `acc_stb`=1, `sel_a`=1, `sel_b_n`=0 and `sel_c`=1. In any other cycle nothing changes and `host_rvalid` stays 0.
- R2: In the cycle after an access, `host_rvalid` is 1 for a read and 0 otherwise. The access is decoded from `reg_sel`/`rd_nwr` as follows:
  - 0/0 puts `host_wdata` on `tx_char` and pulses `tx_char_load` for one cycle.
  - 0/1 returns the received character.
  - 1/0 writes the configuration byte.
  - 1/1 returns the status byte.
- R3: The configuration byte `cfg` has these fields, bit 7 down to bit 0: transmit request, break, interrupt enable, word-length select high, word-length select low, stop select, even parity, parity inhibit. A configuration write with bit 7 = 0 loads all eight bits.
- R4: A configuration write with bit 7 = 1 sets transmit request and leaves bits 6..0 unchanged.
- R5: The status byte has these fields, bit 7 down to bit 0: `tx_hold_empty`, `tx_shift_empty`, peripheral-edge flag, external-status flag, framing error, parity error, overrun, data available. After clear with both transmit inputs at 1, it reads 0xC0.
- R6: A `rx_char_load` pulse has the following effects:
  - It stores `rx_char`.
  - It sets data available.
  - It copies `rx_frm_err` into the framing-error flag.
  - It copies `rx_par_err` into the parity-error flag; the parity-error flag is forced to 0 when `cfg` bit 0 = 1.
  - It sets overrun only if data available was already 1 and no data read happens in the same cycle.
- R7: A data read returns the stored character and clears data available. Overrun keeps its value until the next load.
- R8: There are five interrupt causes:
  - A received character.
  - A rising edge of (`tx_hold_empty` AND transmit request).
  - A rising edge of (`tx_hold_empty` AND `tx_shift_empty`).
  - A falling edge of the synchronised `per_stat_n`.
  - A rising edge of `cts_in` while both transmit inputs are 1.

  The clearing accesses are:
  - A data read clears the first cause.
  - A status read or a character write clears the second and third causes.
  - A status read clears the last two causes.
- R9: `irq_n` is 0 exactly when `cfg` bit 5 is 1 and at least one cause is pending. If a set event and a clearing access fall in the same cycle, the cause stays pending.
- R10: `rts_n` goes to 0 after a character write or after a write that sets transmit request. It returns to 1 once both transmit inputs are 1 while transmit request is 0.
- R11: `ext_stat_n` and `per_stat_n` pass through SYNC_STAGES flops. The status external flag shows the inverted synchronised level. The peripheral-edge flag is the falling-edge cause.
- R12: `rst_n` low clears the configuration byte, the received character and its flags, all causes and request-to-send, so that `irq_n`=1 and `rts_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear |
| acc_stb | input | 1 | Single-cycle access strobe |
| sel_a | input | 1 | Select, active high |
| sel_b_n | input | 1 | Select, active low |
| sel_c | input | 1 | Select, active high |
| reg_sel | input | 1 | 0 data registers, 1 configuration/status |
| rd_nwr | input | 1 | 1 read, 0 write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | Read data valid |
| rx_char | input | 8 | Character from receive engine |
| rx_char_load | input | 1 | Receive engine hands over a character |
| rx_par_err | input | 1 | Parity error of that character |
| rx_frm_err | input | 1 | Framing error of that character |
| tx_hold_empty | input | 1 | Transmit holding stage empty |
| tx_shift_empty | input | 1 | Transmit shifter empty |
| cts_in | input | 1 | Clear-to-send level, high inhibits |
| ext_stat_n | input | 1 | External status, active low, asynchronous |
| per_stat_n | input | 1 | Peripheral status, falling edge counts, asynchronous |
| tx_char | output | 8 | Character to transmit engine |
| tx_char_load | output | 1 | One-cycle load pulse for tx_char |
| cfg | output | 8 | Configuration byte to engines |
| irq_n | output | 1 | Interrupt, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Two events can land on the same clock edge: a host access that clears a cause, and the event that sets that cause. The bench provokes this twice. In the first case it lowers the peripheral input exactly two cycles before a status read, so the synchronised edge and the read share an edge. In the second case it hands over a received character on the same edge as a data read. The judgement is that the status read returns the byte from before that edge, and that the cause remains pending with `irq_n` low. For the receive case, overrun must stay clear and data available must remain set. A cycle-by-cycle model compares every output on every clock, which also catches a cause that is lost or doubled in these collisions.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

   typedef struct packed {
      logic xmit_req;
      logic brk;
      logic int_en;
      logic wlen_hi;
      logic wlen_lo;
      logic stop_sel;
      logic even_par;
      logic par_inh;
   } cfg_t;

   localparam int BYTE_W     = $bits(cfg_t);
   localparam int CAUSE_RXD  = 0;
   localparam int CAUSE_THRE = 1;
   localparam int CAUSE_IDLE = 2;
   localparam int CAUSE_PSI  = 3;
   localparam int CAUSE_CTS  = 4;
   localparam int N_CAUSE    = 5;

endpackage

// File: rtl/uart_host_sync.sv
module uart_host_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial assert (STAGES >= 2) else $error("uart_host_sync: STAGES below 2");

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/uart_host_decode.sv
module uart_host_decode (
   input  logic acc_stb,
   input  logic sel_a,
   input  logic sel_b_n,
   input  logic sel_c,
   input  logic reg_sel,
   input  logic rd_nwr,
   output logic wr_char,
   output logic rd_char,
   output logic wr_cfg,
   output logic rd_stat
);

   logic hit;

   always_comb begin
      hit     = acc_stb & sel_a & ~sel_b_n & sel_c;
      wr_char = hit & ~reg_sel & ~rd_nwr;
      rd_char = hit & ~reg_sel &  rd_nwr;
      wr_cfg  = hit &  reg_sel & ~rd_nwr;
      rd_stat = hit &  reg_sel &  rd_nwr;
   end

endmodule

// File: rtl/uart_host_cause.sv
module uart_host_cause #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);

   initial assert (N >= 1) else $error("uart_host_cause: N below 1");

   generate
      for (genvar i = 0; i < N; i++) begin : g_cause
         logic p_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      p_q <= 1'b0;
            else if (set[i]) p_q <= 1'b1;
            else if (clr[i]) p_q <= 1'b0;
         end

         assign pend[i] = p_q;

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]) else $error("cause %0d lost", i); // R9
         AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !set[i] |=> !pend[i]) else $error("cause %0d stuck", i); // R8
      end
   endgenerate

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
   import uart_host_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_stb,
   input  logic              sel_a,
   input  logic              sel_b_n,
   input  logic              sel_c,
   input  logic              reg_sel,
   input  logic              rd_nwr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              host_rvalid,
   input  logic [BYTE_W-1:0] rx_char,
   input  logic              rx_char_load,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              tx_hold_empty,
   input  logic              tx_shift_empty,
   input  logic              cts_in,
   input  logic              ext_stat_n,
   input  logic              per_stat_n,
   output logic [BYTE_W-1:0] tx_char,
   output logic              tx_char_load,
   output logic [BYTE_W-1:0] cfg,
   output logic              irq_n,
   output logic              rts_n
);

   logic wr_char, rd_char, wr_cfg, rd_stat;
   cfg_t cfg_q;
   logic [BYTE_W-1:0] rxc_q;
   logic oe_q, pe_q, fe_q;
   logic [1:0] stat_s;
   logic psi_prev_q, idle_prev_q, thre_prev_q, cts_prev_q, rts_q;
   logic idle_w, thre_w;
   logic [N_CAUSE-1:0] set_w, clr_w, pend_w;
   logic [BYTE_W-1:0] status_w;

   uart_host_decode u_dec (
      .acc_stb(acc_stb), .sel_a(sel_a), .sel_b_n(sel_b_n), .sel_c(sel_c),
      .reg_sel(reg_sel), .rd_nwr(rd_nwr),
      .wr_char(wr_char), .rd_char(rd_char), .wr_cfg(wr_cfg), .rd_stat(rd_stat)
   );

   uart_host_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({per_stat_n, ext_stat_n}), .q(stat_s)
   );

   always_comb begin
      idle_w = tx_hold_empty & tx_shift_empty;
      thre_w = tx_hold_empty & cfg_q.xmit_req;
      set_w[CAUSE_RXD]  = rx_char_load;
      set_w[CAUSE_THRE] = thre_w & ~thre_prev_q;
      set_w[CAUSE_IDLE] = idle_w & ~idle_prev_q;
      set_w[CAUSE_PSI]  = psi_prev_q & ~stat_s[1];
      set_w[CAUSE_CTS]  = cts_in & ~cts_prev_q & idle_w;
      clr_w[CAUSE_RXD]  = rd_char;
      clr_w[CAUSE_THRE] = rd_stat | wr_char;
      clr_w[CAUSE_IDLE] = rd_stat | wr_char;
      clr_w[CAUSE_PSI]  = rd_stat;
      clr_w[CAUSE_CTS]  = rd_stat;
      status_w = {tx_hold_empty, tx_shift_empty, pend_w[CAUSE_PSI], ~stat_s[0],
                  fe_q, pe_q, oe_q, pend_w[CAUSE_RXD]};
   end

   uart_host_cause #(.N(N_CAUSE)) u_cause (
      .clk(clk), .rst_n(rst_n), .set(set_w), .clr(clr_w), .pend(pend_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         rxc_q       <= '0;
         oe_q        <= 1'b0;
         pe_q        <= 1'b0;
         fe_q        <= 1'b0;
         psi_prev_q  <= 1'b1;
         idle_prev_q <= 1'b1;
         thre_prev_q <= 1'b0;
         cts_prev_q  <= 1'b1;
         rts_q       <= 1'b0;
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
         tx_char     <= '0;
         tx_char_load <= 1'b0;
      end else begin
         if (wr_cfg) begin
            if (host_wdata[BYTE_W-1]) cfg_q.xmit_req <= 1'b1;
            else                      cfg_q <= cfg_t'(host_wdata);
         end
         if (rx_char_load) begin
            rxc_q <= rx_char;
            oe_q  <= pend_w[CAUSE_RXD] & ~rd_char;
            pe_q  <= rx_par_err & ~cfg_q.par_inh;
            fe_q  <= rx_frm_err;
         end
         psi_prev_q  <= stat_s[1];
         idle_prev_q <= idle_w;
         thre_prev_q <= thre_w;
         cts_prev_q  <= cts_in;
         if (wr_char || (wr_cfg && host_wdata[BYTE_W-1])) rts_q <= 1'b1;
         else if (idle_w && !cfg_q.xmit_req)              rts_q <= 1'b0;
         if (rd_char)      host_rdata <= rxc_q;
         else if (rd_stat) host_rdata <= status_w;
         host_rvalid  <= rd_char | rd_stat;
         if (wr_char) tx_char <= host_wdata;
         tx_char_load <= wr_char;
      end
   end

   assign cfg   = cfg_q;
   assign irq_n = ~(cfg_q.int_en & (|pend_w));
   assign rts_n = ~rts_q;

   AST_NO_STRAY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_stb |=> !host_rvalid && !tx_char_load) else $error("stray access"); // R1
   AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_char || rd_stat) |=> host_rvalid) else $error("read not flagged"); // R2
   AST_PLAIN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg && !host_wdata[BYTE_W-1] |=> cfg == $past(host_wdata)) else $error("cfg load"); // R3
   AST_TR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg && host_wdata[BYTE_W-1] |=> cfg[BYTE_W-1] && cfg[BYTE_W-2:0] == $past(cfg[BYTE_W-2:0]))
      else $error("tr write altered cfg"); // R4
   AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_load && status_w[0] && !rd_char |=> oe_q) else $error("overrun missed"); // R6
   AST_PAR_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_load && cfg[0] |=> !status_w[2]) else $error("parity not inhibited"); // R6
   AST_RTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_char |=> !rts_n) else $error("rts not raised"); // R10

endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_stb = 0, sel_a = 1, sel_b_n = 0, sel_c = 1, reg_sel = 0, rd_nwr = 0;
   logic [7:0] host_wdata = 0, rx_char = 0;
   logic rx_char_load = 0, rx_par_err = 0, rx_frm_err = 0;
   logic tx_hold_empty = 1, tx_shift_empty = 1, cts_in = 0, ext_stat_n = 1, per_stat_n = 1;
   logic [7:0] host_rdata, tx_char, cfg;
   logic host_rvalid, tx_char_load, irq_n, rts_n;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_host_regs i_uart_host_regs (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .sel_a(sel_a), .sel_b_n(sel_b_n),
      .sel_c(sel_c), .reg_sel(reg_sel), .rd_nwr(rd_nwr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .rx_char(rx_char),
      .rx_char_load(rx_char_load), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty), .cts_in(cts_in),
      .ext_stat_n(ext_stat_n), .per_stat_n(per_stat_n), .tx_char(tx_char),
      .tx_char_load(tx_char_load), .cfg(cfg), .irq_n(irq_n), .rts_n(rts_n)
   );

   // behavioural reference model
   bit [7:0] m_cfg, m_rxc, m_rdata, m_txc;
   bit m_oe, m_pe, m_fe, m_rvld, m_txl, m_rts;
   bit [4:0] m_pend;
   bit [1:0] m_es, m_ps;
   bit m_psi_prev, m_idle_prev, m_thre_prev, m_cts_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 0; m_rxc = 0; m_rdata = 0; m_txc = 0;
         m_oe = 0; m_pe = 0; m_fe = 0; m_rvld = 0; m_txl = 0; m_rts = 0;
         m_pend = 0; m_es = 2'b11; m_ps = 2'b11;
         m_psi_prev = 1; m_idle_prev = 1; m_thre_prev = 0; m_cts_prev = 1;
      end else begin
         bit acc, wtx, rrx, wct, rst;
         bit idle, thre;
         bit [7:0] st, old_cfg;
         bit [4:0] sv, cv;
         acc = acc_stb && sel_a && !sel_b_n && sel_c;
         wtx = acc && !reg_sel && !rd_nwr;
         rrx = acc && !reg_sel && rd_nwr;
         wct = acc && reg_sel && !rd_nwr;
         rst = acc && reg_sel && rd_nwr;
         old_cfg = m_cfg;
         idle = tx_hold_empty && tx_shift_empty;
         thre = tx_hold_empty && old_cfg[7];
         st = {tx_hold_empty, tx_shift_empty, m_pend[3], !m_es[1], m_fe, m_pe, m_oe, m_pend[0]};
         sv = {cts_in && !m_cts_prev && idle, m_psi_prev && !m_ps[1],
               idle && !m_idle_prev, thre && !m_thre_prev, rx_char_load};
         cv = {rst, rst, rst || wtx, rst || wtx, rrx};
         if (rrx) m_rdata = m_rxc;
         else if (rst) m_rdata = st;
         m_rvld = rrx || rst;
         if (rx_char_load) begin
            m_oe = m_pend[0] && !rrx;
            m_pe = rx_par_err && !old_cfg[0];
            m_fe = rx_frm_err;
            m_rxc = rx_char;
         end
         for (int i = 0; i < 5; i++) m_pend[i] = sv[i] || (m_pend[i] && !cv[i]);
         if (wtx || (wct && host_wdata[7])) m_rts = 1;
         else if (idle && !old_cfg[7]) m_rts = 0;
         if (wct) m_cfg = host_wdata[7] ? (old_cfg | 8'h80) : host_wdata;
         if (wtx) m_txc = host_wdata;
         m_txl = wtx;
         m_thre_prev = thre; m_idle_prev = idle; m_cts_prev = cts_in;
         m_psi_prev = m_ps[1]; m_ps = {m_ps[0], per_stat_n}; m_es = {m_es[0], ext_stat_n};
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2 rdata", host_rdata, m_rdata);
         chk("R2 rvalid", {7'b0, host_rvalid}, {7'b0, m_rvld});
         chk("R2 tx_char", tx_char, m_txc);
         chk("R2 tx_load", {7'b0, tx_char_load}, {7'b0, m_txl});
         chk("R3 cfg", cfg, m_cfg);
         chk("R9 irq_n", {7'b0, irq_n}, {7'b0, !(m_cfg[5] && (|m_pend))});
         chk("R10 rts_n", {7'b0, rts_n}, {7'b0, !m_rts});
      end
   end

   task automatic access(input logic rs, input logic rw, input logic [7:0] d);
      @(negedge clk);
      acc_stb = 1; reg_sel = rs; rd_nwr = rw; host_wdata = d;
      @(negedge clk);
      acc_stb = 0;
   endtask

   task automatic rx_pulse(input logic [7:0] c, input logic pe, input logic fe);
      @(negedge clk);
      rx_char = c; rx_par_err = pe; rx_frm_err = fe; rx_char_load = 1;
      @(negedge clk);
      rx_char_load = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 / R5 reset state
      chk("R12 cfg", cfg, 8'h00);
      chk("R12 irq_n", {7'b0, irq_n}, 8'h01);
      chk("R12 rts_n", {7'b0, rts_n}, 8'h01);
      access(1, 1, 0);
      chk("R5 status after clear", host_rdata, 8'hC0);
      // R1 deselected accesses
      sel_b_n = 1;
      access(1, 0, 8'h3A);
      chk("R1 cfg untouched", cfg, 8'h00);
      sel_b_n = 0; sel_a = 0;
      access(1, 1, 0);
      chk("R1 no read valid", {7'b0, host_rvalid}, 8'h00);
      sel_a = 1;
      // R3 plain configuration write
      access(1, 0, 8'h3A);
      chk("R3 cfg load", cfg, 8'h3A);
      // R4 transmit request write
      access(1, 0, 8'h80);
      chk("R4 cfg kept", cfg, 8'hBA);
      chk("R10 rts active", {7'b0, rts_n}, 8'h00);
      @(negedge clk);
      chk("R8 thre irq", {7'b0, irq_n}, 8'h00);
      access(1, 1, 0);
      chk("R5 status", host_rdata, 8'hC0);
      chk("R8 thre cleared", {7'b0, irq_n}, 8'h01);
      // R2 character write
      access(0, 0, 8'hA5);
      chk("R2 tx char", tx_char, 8'hA5);
      chk("R2 tx pulse", {7'b0, tx_char_load}, 8'h01);
      // R6 receive with errors
      rx_pulse(8'h55, 1, 1);
      chk("R8 rx irq", {7'b0, irq_n}, 8'h00);
      access(1, 1, 0);
      chk("R6 status errors", host_rdata, 8'hCD);
      rx_pulse(8'h66, 0, 0);
      access(1, 1, 0);
      chk("R6 overrun", host_rdata, 8'hC3);
      access(0, 1, 0);
      chk("R7 data read", host_rdata, 8'h66);
      access(1, 1, 0);
      chk("R7 da cleared", host_rdata, 8'hC2);
      // parity inhibit, request drop
      access(1, 0, 8'h3B);
      @(negedge clk);
      chk("R10 rts released", {7'b0, rts_n}, 8'h01);
      rx_pulse(8'h77, 1, 0);
      access(1, 1, 0);
      chk("R6 parity inhibit", host_rdata, 8'hC1);
      // R11 external level
      ext_stat_n = 0;
      repeat (3) @(negedge clk);
      access(1, 1, 0);
      chk("R11 ext status", host_rdata, 8'hD1);
      ext_stat_n = 1;
      access(0, 1, 0);
      repeat (3) @(negedge clk);
      // R9 peripheral edge landing on a status read
      per_stat_n = 0;
      @(negedge clk);
      access(1, 1, 0);
      chk("R9 read before edge", host_rdata, 8'hC0);
      chk("R9 set wins", {7'b0, irq_n}, 8'h00);
      access(1, 1, 0);
      chk("R11 psi flag", host_rdata, 8'hE0);
      chk("R8 psi cleared", {7'b0, irq_n}, 8'h01);
      per_stat_n = 1;
      repeat (3) @(negedge clk);
      // R8 clear-to-send edge
      cts_in = 1;
      @(negedge clk);
      chk("R8 cts irq", {7'b0, irq_n}, 8'h00);
      access(1, 1, 0);
      chk("R8 cts cleared", {7'b0, irq_n}, 8'h01);
      cts_in = 0;
      // R6 load on the same edge as a data read
      rx_pulse(8'h11, 0, 0);
      @(negedge clk);
      acc_stb = 1; reg_sel = 0; rd_nwr = 1;
      rx_char = 8'h22; rx_char_load = 1;
      @(negedge clk);
      acc_stb = 0; rx_char_load = 0;
      chk("R7 old char", host_rdata, 8'h11);
      access(1, 1, 0);
      chk("R6 no overrun on read collision", host_rdata, 8'hC1);
      // R12 clear mid-run
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      chk("R12 cfg cleared", cfg, 8'h00);
      chk("R12 irq idle", {7'b0, irq_n}, 8'h01);
      chk("R12 rts idle", {7'b0, rts_n}, 8'h01);
      access(1, 1, 0);
      chk("R12 status cleared", host_rdata, 8'hC0);
      repeat (2) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule